// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from twenty sources (sixteen external lines plus four on-chip requesters) and presents a single interrupt line to one processor. Each source has a 32-bit configuration word holding an enable mask, a trigger style, a 4-bit priority and an 8-bit vector. The controller picks the most urgent eligible request and compares it against a software-set task priority and against whatever the processor is already servicing. It raises the processor interrupt only when that request beats both.

Software claims an interrupt by reading the acknowledge address, which returns the winning vector and records that source as in service. It retires the interrupt by writing anything to the end-of-interrupt address. In-service sources form a stack, so a more urgent request can preempt a handler that is already running. A self-clearing reset bit in the global word returns the whole controller to its power-up state.

Top module: `vpic_top`

## Requirements
- R1: The bus uses word addresses. Source i (0 to 19) sits at address i, global word at 0x20, configuration word at 0x21, task priority at 0x22, acknowledge at 0x23 and end-of-interrupt at 0x24. A source word reads as mask at bit 31, activity at bit 30, polarity at bit 23, sense at bit 22, priority at bits 19:16 and vector at bits 7:0. Every other bit reads 0. After reset every source reads 0x80000000.
- R2: A source is in request when it is unmasked and its trigger condition holds. Its activity bit reads 1 while it is in request or in service. While activity is 1, a write changes only the mask bit and leaves polarity, sense, priority and vector as they were. While activity is 0, a write updates all of these fields.
- R3: Writing 1 to global bit 31 reads back as 1 for exactly one cycle and then clears. When it clears, every source is masked with zeroed fields, the task priority is 0xF, the configuration word and mode bit are 0, and no source is pending or in service.
- R4: Global bit 29 is a mode bit that reads back as last written.
- R5: The task priority (bits 3:0 at 0x22) resets to 0xF and reads back as written. Upper bits read 0.
- R6: A read of 0x23 returns the vector of the winning source in bits 7:0 and marks that source in service. When no source is eligible it returns 0xFF and changes no state.
- R7: A source is eligible when it is in request, not already in service, and its priority is strictly greater than both the task priority and the priority of the most recent in-service source. Priority 0 is therefore never eligible. Among eligible sources the highest priority wins, and ties go to the lowest index.
- R8: `cpu_irq_o` is registered. It is high in the cycle after one in which some source is eligible, and low otherwise.
- R9: Sense 1 is level-triggered and sense 0 is edge-triggered. Polarity 1 selects active-high or rising edge, and polarity 0 selects active-low or falling edge. An edge seen while unmasked is held pending until that source is acknowledged, even after the line returns.
- R10: A write of any value to 0x24 removes the most recent in-service source, which re-exposes the one beneath it. With nothing in service the write has no effect.
- R11: Bits 30:28 (ratio) and 27 (serial enable) at 0x21 are plain storage that resets to 0. All other bits there read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines_i | input | NUM_SRC | Raw request lines, one per source |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (needed for acknowledge side effect) |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| cpu_irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench targets equal-priority ties, priority 0, and a task priority that equals the request priority or is 0xF. A wrong comparator or a wrong tie rule returns the other vector, or a vector where 0xFF is due. Nesting is exercised with a lower-priority request that arrives while a higher one is in service. A controller that compares only against the task priority would wrongly accept it, and one that pops the wrong entry would let it through one retirement too early. Edge requests are pulsed for one cycle and then acknowledged twice: a latch that drops early loses the interrupt, and one that is never cleared re-delivers it. The field lock is probed by writing during service and reading back, and the self-clearing reset bit is read in the cycle after it is set.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

  localparam int PRIO_W = 4;
  localparam int VEC_W  = 8;

  // source word bit positions (software decodes these)
  localparam int B_MASK  = 31;
  localparam int B_ACT   = 30;
  localparam int B_POL   = 23;
  localparam int B_SENSE = 22;
  localparam int B_PRIO  = 16;

  // global / configuration word bit positions
  localparam int B_GRST  = 31;
  localparam int B_GMODE = 29;
  localparam int B_RATIO = 28;
  localparam int B_SER   = 27;

  // word addresses
  localparam int A_GLOBAL = 32;
  localparam int A_CFG    = 33;
  localparam int A_TASK   = 34;
  localparam int A_ACK    = 35;
  localparam int A_EOI    = 36;

  localparam logic [VEC_W-1:0] SPURIOUS_VEC = 8'hFF;

  typedef struct packed {
    logic              mask;
    logic              pol;
    logic              sense;
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  vec;
  } src_cfg_t;

  localparam src_cfg_t SRC_CFG_RST = '{mask: 1'b1, pol: 1'b0, sense: 1'b0,
                                       prio: '0, vec: '0};

endpackage

// File: rtl/vpic_src_cell.sv
module vpic_src_cell
  import vpic_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     soft_clr_i,
  input  logic     line_i,
  input  logic     wr_en_i,
  input  src_cfg_t wcfg_i,
  input  logic     ack_take_i,
  input  logic     in_svc_i,
  output src_cfg_t cfg_o,
  output logic     pending_o,
  output logic     active_o
);

  src_cfg_t cfg_q, cfg_d;
  logic     cfg_en;
  logic     line_prev_q;
  logic     edge_lat_q, edge_lat_d;
  logic     hit_level, hit_edge;

  assign hit_level = cfg_q.pol ? line_i : ~line_i;
  assign hit_edge  = cfg_q.pol ? (line_i & ~line_prev_q) : (~line_i & line_prev_q);

  assign pending_o = ~cfg_q.mask & (cfg_q.sense ? hit_level : edge_lat_q);
  assign active_o  = pending_o | in_svc_i;
  assign cfg_o     = cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en_i) begin
      cfg_d.mask = wcfg_i.mask;
      if (!active_o) begin
        cfg_d.pol   = wcfg_i.pol;
        cfg_d.sense = wcfg_i.sense;
        cfg_d.prio  = wcfg_i.prio;
        cfg_d.vec   = wcfg_i.vec;
      end
    end
    if (soft_clr_i) cfg_d = SRC_CFG_RST;
  end

  assign cfg_en = wr_en_i | soft_clr_i;

  always_comb begin
    edge_lat_d = edge_lat_q;
    if (ack_take_i) edge_lat_d = 1'b0;
    if (!cfg_q.mask && !cfg_q.sense && hit_edge) edge_lat_d = 1'b1;
    if (soft_clr_i) edge_lat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= SRC_CFG_RST;
      line_prev_q <= 1'b0;
      edge_lat_q  <= 1'b0;
    end else begin
      if (cfg_en) cfg_q <= cfg_d;
      line_prev_q <= line_i;
      edge_lat_q  <= edge_lat_d;
    end
  end

  // R2
  field_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && active_o && !soft_clr_i) |=>
      (cfg_q.prio == $past(cfg_q.prio)) && (cfg_q.vec == $past(cfg_q.vec)) &&
      (cfg_q.pol == $past(cfg_q.pol)) && (cfg_q.sense == $past(cfg_q.sense)));

  // R9
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_lat_q && !ack_take_i && !soft_clr_i) |=> edge_lat_q);

endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter #(
  parameter int NUM_SRC = 20,
  parameter int IDX_W   = 5,
  parameter int PRIO_W  = 4
) (
  input  logic [NUM_SRC-1:0]             req_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]              floor_i,
  output logic                           win_valid_o,
  output logic [IDX_W-1:0]               win_idx_o,
  output logic [PRIO_W-1:0]              win_prio_o
);

  // strict compare keeps the lowest index on equal priority
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    win_prio_o  = floor_i;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req_i[i] && (prio_i[i] > win_prio_o)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        win_prio_o  = prio_i[i];
      end
    end
  end

endmodule

// File: rtl/vpic_isr_stack.sv
module vpic_isr_stack #(
  parameter int DEPTH   = 16,
  parameter int NUM_SRC = 20,
  parameter int IDX_W   = 5,
  parameter int PRIO_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   soft_clr_i,
  input  logic                   push_i,
  input  logic [IDX_W-1:0]       push_idx_i,
  input  logic [PRIO_W-1:0]      push_prio_i,
  input  logic                   pop_i,
  output logic [PRIO_W-1:0]      top_prio_o,
  output logic [$clog2(DEPTH+1)-1:0] depth_o,
  output logic [NUM_SRC-1:0]     in_svc_o
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);

  logic [IDX_W-1:0]  idx_q  [DEPTH];
  logic [PRIO_W-1:0] prio_q [DEPTH];
  logic [CNT_W-1:0]  depth_q, depth_d;
  logic              pop_eff, push_ok;
  logic [CNT_W-1:0]  slot;
  logic [PTR_W-1:0]  wr_ptr, top_ptr;

  assign pop_eff = pop_i && (depth_q != '0);
  assign slot    = depth_q - CNT_W'(pop_eff);
  assign push_ok = push_i && (int'(slot) < DEPTH);
  assign wr_ptr  = PTR_W'(slot);
  assign top_ptr = PTR_W'(depth_q - CNT_W'(1));

  always_comb begin
    depth_d = slot + CNT_W'(push_ok);
    if (soft_clr_i) depth_d = '0;
  end

  assign top_prio_o = (depth_q == '0) ? '0 : prio_q[top_ptr];
  assign depth_o    = depth_q;

  always_comb begin
    in_svc_o = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if ((e < int'(depth_q)) && (int'(idx_q[e]) < NUM_SRC)) in_svc_o[idx_q[e]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        idx_q[e]  <= '0;
        prio_q[e] <= '0;
      end
    end else begin
      depth_q <= depth_d;
      if (push_ok && !soft_clr_i) begin
        idx_q[wr_ptr]  <= push_idx_i;
        prio_q[wr_ptr] <= push_prio_i;
      end
    end
  end

  // R7
  push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && (depth_q != '0)) |-> (push_prio_i > top_prio_o));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |-> (int'(depth_q) < DEPTH));

endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int NUM_SRC   = 20,
  parameter int ADDR_W    = 6,
  parameter int SVC_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_lines_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               cpu_irq_o
);

  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int CNT_W = $clog2(SVC_DEPTH + 1);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ns = rst_pipe_q[1];

  // address decode
  logic hit_glb, hit_cfg, hit_task, ack_rd, eoi_wr;
  assign hit_glb  = bus_addr_i == ADDR_W'(A_GLOBAL);
  assign hit_cfg  = bus_addr_i == ADDR_W'(A_CFG);
  assign hit_task = bus_addr_i == ADDR_W'(A_TASK);
  assign ack_rd   = bus_rd_i && (bus_addr_i == ADDR_W'(A_ACK));
  assign eoi_wr   = bus_wr_i && (bus_addr_i == ADDR_W'(A_EOI));

  // global registers
  logic             glb_rst_q, glb_rst_d;
  logic             mode_q, mode_d;
  logic [2:0]       ratio_q, ratio_d;
  logic             ser_q, ser_d;
  logic [PRIO_W-1:0] tp_q, tp_d;
  logic             irq_q;

  // source / arbitration wiring
  src_cfg_t                      wcfg;
  src_cfg_t                      cfg     [NUM_SRC];
  logic [NUM_SRC-1:0]            pending, active, in_svc;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_vec;
  logic                          win_valid;
  logic [IDX_W-1:0]              win_idx;
  logic [PRIO_W-1:0]             win_prio, top_prio, floor_prio;
  logic [CNT_W-1:0]              svc_depth;
  logic                          ack_hit;

  assign wcfg = '{mask:  bus_wdata_i[B_MASK],
                  pol:   bus_wdata_i[B_POL],
                  sense: bus_wdata_i[B_SENSE],
                  prio:  bus_wdata_i[B_PRIO +: PRIO_W],
                  vec:   bus_wdata_i[VEC_W-1:0]};

  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata_i[30], bus_wdata_i[26:24], bus_wdata_i[21:20],
                          bus_wdata_i[15:8]};

  assign ack_hit = ack_rd && win_valid;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_src
      vpic_src_cell u_cell (
        .clk        (clk),
        .rst_n      (rst_ns),
        .soft_clr_i (glb_rst_q),
        .line_i     (irq_lines_i[g]),
        .wr_en_i    (bus_wr_i && (bus_addr_i == ADDR_W'(g))),
        .wcfg_i     (wcfg),
        .ack_take_i (ack_hit && (win_idx == IDX_W'(g))),
        .in_svc_i   (in_svc[g]),
        .cfg_o      (cfg[g]),
        .pending_o  (pending[g]),
        .active_o   (active[g])
      );
      assign prio_vec[g] = cfg[g].prio;
    end
  endgenerate

  assign floor_prio = (tp_q > top_prio) ? tp_q : top_prio;

  vpic_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_arb (
    .req_i       (pending & ~in_svc),
    .prio_i      (prio_vec),
    .floor_i     (floor_prio),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_prio_o  (win_prio)
  );

  vpic_isr_stack #(.DEPTH(SVC_DEPTH), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W),
                   .PRIO_W(PRIO_W)) u_stack (
    .clk         (clk),
    .rst_n       (rst_ns),
    .soft_clr_i  (glb_rst_q),
    .push_i      (ack_hit),
    .push_idx_i  (win_idx),
    .push_prio_i (win_prio),
    .pop_i       (eoi_wr),
    .top_prio_o  (top_prio),
    .depth_o     (svc_depth),
    .in_svc_o    (in_svc)
  );

  // next state of global registers; the reset pulse overrides writes
  always_comb begin
    glb_rst_d = bus_wr_i && hit_glb && bus_wdata_i[B_GRST];
    mode_d    = mode_q;
    ratio_d   = ratio_q;
    ser_d     = ser_q;
    tp_d      = tp_q;
    if (bus_wr_i && hit_glb)  mode_d = bus_wdata_i[B_GMODE];
    if (bus_wr_i && hit_cfg) begin
      ratio_d = bus_wdata_i[B_RATIO +: 3];
      ser_d   = bus_wdata_i[B_SER];
    end
    if (bus_wr_i && hit_task) tp_d = bus_wdata_i[PRIO_W-1:0];
    if (glb_rst_q) begin
      glb_rst_d = 1'b0;
      mode_d    = 1'b0;
      ratio_d   = 3'd0;
      ser_d     = 1'b0;
      tp_d      = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      glb_rst_q <= 1'b0;
      mode_q    <= 1'b0;
      ratio_q   <= 3'd0;
      ser_q     <= 1'b0;
      tp_q      <= '1;
      irq_q     <= 1'b0;
    end else begin
      glb_rst_q <= glb_rst_d;
      mode_q    <= mode_d;
      ratio_q   <= ratio_d;
      ser_q     <= ser_d;
      tp_q      <= tp_d;
      irq_q     <= win_valid && !glb_rst_q;
    end
  end

  assign cpu_irq_o = irq_q;

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    if (int'(bus_addr_i) < NUM_SRC) begin
      bus_rdata_o[B_MASK]              = cfg[bus_addr_i].mask;
      bus_rdata_o[B_ACT]               = active[bus_addr_i];
      bus_rdata_o[B_POL]               = cfg[bus_addr_i].pol;
      bus_rdata_o[B_SENSE]             = cfg[bus_addr_i].sense;
      bus_rdata_o[B_PRIO +: PRIO_W]    = cfg[bus_addr_i].prio;
      bus_rdata_o[VEC_W-1:0]           = cfg[bus_addr_i].vec;
    end else if (hit_glb) begin
      bus_rdata_o[B_GRST]  = glb_rst_q;
      bus_rdata_o[B_GMODE] = mode_q;
    end else if (hit_cfg) begin
      bus_rdata_o[B_RATIO +: 3] = ratio_q;
      bus_rdata_o[B_SER]        = ser_q;
    end else if (hit_task) begin
      bus_rdata_o[PRIO_W-1:0] = tp_q;
    end else if (bus_addr_i == ADDR_W'(A_ACK)) begin
      bus_rdata_o[VEC_W-1:0] = win_valid ? cfg[win_idx].vec : SPURIOUS_VEC;
    end
  end

  // R3
  soft_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    glb_rst_q |=> !glb_rst_q);

  // R3
  soft_rst_task_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    glb_rst_q |=> (tp_q == '1) && (svc_depth == '0));

  // R6
  spurious_nopush_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (ack_rd && !win_valid && !bus_wr_i && !glb_rst_q) |=> (svc_depth == $past(svc_depth)));

endmodule

// File: tb/tb_vpic_top.sv
`timescale 1ns/1ps
module tb_vpic_top;

  localparam int NSRC = 20;
  localparam int AW   = 6;
  localparam logic [AW-1:0] AD_GLB = 6'h20, AD_CFG = 6'h21, AD_TASK = 6'h22,
                            AD_ACK = 6'h23, AD_EOI = 6'h24;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] lines;
  logic            wr, rd;
  logic [AW-1:0]   addr;
  logic [31:0]     wdata, rdata;
  logic            irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  vpic_top dut (
    .clk(clk), .rst_n(rst_n), .irq_lines_i(lines), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cpu_irq_o(irq)
  );

  // idx A, prio A, idx B, prio B, task prio, expected ack vector
  localparam logic [29:0] TBL [9] = '{
    {5'd2,  4'd5,  5'd9,  4'd7,  4'd0,  8'h49},
    {5'd2,  4'd7,  5'd9,  4'd7,  4'd0,  8'h42},
    {5'd12, 4'd6,  5'd1,  4'd6,  4'd0,  8'h41},
    {5'd3,  4'd4,  5'd8,  4'd2,  4'd4,  8'hFF},
    {5'd3,  4'd5,  5'd8,  4'd2,  4'd4,  8'h43},
    {5'd0,  4'd0,  5'd19, 4'd0,  4'd0,  8'hFF},
    {5'd0,  4'd15, 5'd19, 4'd14, 4'd15, 8'hFF},
    {5'd0,  4'd15, 5'd19, 4'd14, 4'd14, 8'h40},
    {5'd16, 4'd1,  5'd17, 4'd9,  4'd8,  8'h51}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick(1);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    tick(1);
    rd = 1'b0;
  endtask

  task automatic soft_reset();
    logic [31:0] v;
    bus_wr(AD_GLB, 32'h8000_0000);
    for (int k = 0; k < 4; k++) begin
      bus_rd(AD_GLB, v);
      if (!v[31]) break;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic [31:0] da, db;
    rst_n = 1'b0; lines = '0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // reset state
    check("R8 irq after reset", {31'd0, irq}, 32'd0);
    bus_rd(6'd0, v);    check("R1 source reset value", v, 32'h8000_0000);
    bus_rd(6'd19, v);   check("R1 last source reset value", v, 32'h8000_0000);
    bus_rd(AD_TASK, v); check("R5 task reset", v, 32'h0000_000F);
    bus_rd(AD_GLB, v);  check("R3 global reset", v, 32'h0);
    bus_rd(AD_ACK, v);  check("R6 ack with nothing eligible", v, 32'h0000_00FF);

    // table walk: two level sources competing
    foreach (TBL[t]) begin
      int ia, ib;
      logic [7:0] ex;
      ia = int'(TBL[t][29:25]);
      ib = int'(TBL[t][20:16]);
      ex = TBL[t][7:0];
      soft_reset();
      bus_wr(AD_TASK, {28'd0, TBL[t][11:8]});
      da = 32'h00C0_0000 | ({28'd0, TBL[t][24:21]} << 16) | (32'h40 + ia);
      db = 32'h00C0_0000 | ({28'd0, TBL[t][15:12]} << 16) | (32'h40 + ib);
      bus_wr(AW'(ia), da);
      bus_wr(AW'(ib), db);
      lines[ia] = 1'b1; lines[ib] = 1'b1;
      tick(2);
      check($sformatf("R8 irq table row %0d", t), {31'd0, irq}, {31'd0, (ex != 8'hFF)});
      bus_rd(AD_ACK, v);
      check($sformatf("R7 ack table row %0d", t), v, {24'd0, ex});
      lines = '0;
      if (ex != 8'hFF) bus_wr(AD_EOI, 32'h0);
    end

    // mode bit and configuration storage
    soft_reset();
    bus_wr(AD_GLB, 32'h2000_0000);
    bus_rd(AD_GLB, v);  check("R4 mode readback", v, 32'h2000_0000);
    bus_wr(AD_CFG, 32'hFFFF_FFFF);
    bus_rd(AD_CFG, v);  check("R11 config storage", v, 32'h7800_0000);
    bus_wr(AD_TASK, 32'h1234_5677);
    bus_rd(AD_TASK, v); check("R5 task write", v, 32'h0000_0007);

    // soft reset with a source in service
    bus_wr(AD_TASK, 32'h0);
    bus_wr(6'd5, 32'h00C3_0015);
    lines[5] = 1'b1;
    tick(2);
    bus_rd(AD_ACK, v);  check("R6 ack before soft reset", v, 32'h15);
    bus_wr(AD_GLB, 32'hA000_0000);
    bus_rd(AD_GLB, v);  check("R3 reset bit visible one cycle", v, 32'hA000_0000);
    bus_rd(AD_GLB, v);  check("R3 reset bit cleared", v, 32'h0);
    bus_rd(AD_TASK, v); check("R3 task after soft reset", v, 32'hF);
    bus_rd(6'd5, v);    check("R3 source masked, not in service", v, 32'h8000_0000);
    bus_rd(AD_CFG, v);  check("R3 config cleared", v, 32'h0);
    check("R3 irq after soft reset", {31'd0, irq}, 32'd0);
    lines = '0;

    // edge trigger, activity, field lock
    soft_reset();
    bus_wr(AD_TASK, 32'h0);
    bus_wr(6'd3, 32'h0086_0033);
    lines[3] = 1'b1; tick(1); lines[3] = 1'b0;
    tick(2);
    check("R9 edge held after pulse", {31'd0, irq}, 32'd1);
    bus_rd(6'd3, v);    check("R2 activity while pending", v, 32'h4086_0033);
    bus_rd(AD_ACK, v);  check("R6 ack edge source", v, 32'h33);
    bus_rd(AD_ACK, v);  check("R9 edge cleared by ack", v, 32'hFF);
    tick(2);
    check("R8 irq low while serviced", {31'd0, irq}, 32'd0);
    bus_wr(6'd3, 32'h000A_0077);
    bus_rd(6'd3, v);    check("R2 fields locked in service", v, 32'h4086_0033);
    bus_wr(6'd3, 32'h8086_0033);
    bus_rd(6'd3, v);    check("R2 mask writable in service", v, 32'hC086_0033);
    bus_wr(AD_EOI, 32'h0);
    bus_rd(6'd3, v);    check("R10 eoi clears activity", v, 32'h8086_0033);
    bus_wr(6'd3, 32'h0009_0055);
    bus_rd(6'd3, v);    check("R2 fields accepted when idle", v, 32'h0009_0055);

    // active-low level
    soft_reset();
    bus_wr(AD_TASK, 32'h0);
    bus_wr(6'd4, 32'h0042_0024);
    tick(2);
    check("R9 active-low level raises irq", {31'd0, irq}, 32'd1);
    bus_rd(AD_ACK, v);  check("R9 ack active-low source", v, 32'h24);
    lines[4] = 1'b1;
    bus_wr(AD_EOI, 32'h0);
    tick(2);
    check("R9 level released", {31'd0, irq}, 32'd0);
    bus_rd(AD_ACK, v);  check("R9 no request after release", v, 32'hFF);
    lines = '0;

    // nesting
    soft_reset();
    bus_wr(AD_TASK, 32'h0);
    bus_wr(6'd5, 32'h00C3_0015);
    bus_wr(6'd6, 32'h00C7_0016);
    bus_wr(6'd7, 32'h00C2_0017);
    lines[5] = 1'b1;
    tick(2);
    bus_rd(AD_ACK, v);  check("R6 first level ack", v, 32'h15);
    lines[6] = 1'b1; lines[7] = 1'b1;
    tick(2);
    check("R7 higher priority nests", {31'd0, irq}, 32'd1);
    bus_rd(AD_ACK, v);  check("R7 nested ack", v, 32'h16);
    tick(2);
    check("R7 lower priority blocked", {31'd0, irq}, 32'd0);
    bus_rd(AD_ACK, v);  check("R7 ack blocked by in-service", v, 32'hFF);
    lines[6] = 1'b0;
    bus_wr(AD_EOI, 32'h0);
    bus_rd(AD_ACK, v);  check("R10 pop exposes priority 3", v, 32'hFF);
    lines[5] = 1'b0;
    bus_wr(AD_EOI, 32'h0);
    bus_rd(AD_ACK, v);  check("R10 second pop frees priority 2", v, 32'h17);
    bus_wr(AD_EOI, 32'h0);
    bus_wr(AD_EOI, 32'h0);
    lines = '0;
    tick(2);
    check("R10 eoi on empty stack harmless", {31'd0, irq}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule